// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. It divides the system clock down to a SAR clock and picks a start event from one of four sources: a software start strobe, two timer overflow pulses, or a rising edge on an asynchronous convert-start pin. It then runs a tracking phase and a conversion phase, and drives the trial code for the capacitor DAC. It reads the comparator decision once per SAR clock and reports the result as a 16-bit word, either left- or right-justified.

In the default tracking mode the sampler follows the input whenever the block is idle, and conversion starts as soon as a start is accepted. In low-power tracking mode, an internal start is followed by three SAR clocks of tracking before conversion begins. With the pin as the source, the sampler tracks while the pin is low and conversion starts on the pin's rising edge. A sticky completion flag is set each time a conversion finishes, and it drives an interrupt request through an enable.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy, the completion flag, irq and data_out are all 0. With low-power mode off, track reads 1.
- R2: start_mode selects the only accepted start source. 2'b00 is sw_start, 2'b01 is tmr3_ovf, 2'b10 is a rising edge of ext_start and 2'b11 is tmr2_ovf. Pulses on sources that are not selected start nothing.
- R3: One SAR clock lasts clk_div+1 system clocks, and its phase is realigned when a start is accepted. In default tracking mode, busy rises on the clock edge that accepts the start and stays high for exactly 16*(clk_div+1) cycles.
- R4: In low-power mode with an internal source (modes 00, 01, 11), busy lasts 19*(clk_div+1) cycles. track is high for the first 3*(clk_div+1) of them and low for the rest.
- R5: ext_start passes through a two-flop synchronizer, so busy rises on the third clock edge after the pin goes high. In mode 2'b10 a conversion lasts 16*(clk_div+1) cycles in both tracking modes. In low-power mode, track is high while the block is idle and the pin is low.
- R6: The clock edge on which busy falls also sets done_flag. irq equals done_flag AND irq_en.
- R7: done_flag holds until sw_clr_flag clears it. If a clear and a completion fall on the same edge, the completion wins.
- R8: The conversion is a binary search from MSB to LSB. Its first trial code is 10'h200, and one comparator decision is taken per SAR clock (cmp_in=1 keeps the trial bit). The final code is the largest code for which cmp_in would be 1.
- R9: With left_just=0, data_out is {6'b0, code}. With left_just=1 it is {code, 6'b0}. The justify selection acts on the stored code at once.
- R10: A start event that arrives while busy is 1 is ignored, and the conversion length does not change.
- R11: data_out changes only when a conversion completes. During a conversion it keeps the previous result.
- R12: In default tracking mode, track equals NOT busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | SAR clock period minus one, in system clocks |
| start_mode | input | 2 | Start source select |
| lp_track | input | 1 | Low-power tracking mode |
| left_just | input | 1 | Left-justify the result in data_out |
| irq_en | input | 1 | Interrupt enable |
| sw_start | input | 1 | Software start strobe |
| sw_clr_flag | input | 1 | Software clear of the completion flag |
| tmr3_ovf | input | 1 | First timer overflow pulse |
| tmr2_ovf | input | 1 | Second timer overflow pulse |
| ext_start | input | 1 | Asynchronous convert-start pin |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | RES_W | Trial code for the DAC |
| track | output | 1 | Track-and-hold control, 1 = track |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | Interrupt request |
| data_out | output | DATA_W | Justified conversion result |

## Verification
A corrupted phase counter or a misaligned divider shows up at the ports as a busy window that misses its exact cycle count. The error can be seen on the edge where busy falls, at most 19 SAR clocks after the start. A wrong bit-select or trial register makes the final code differ from the comparator model's input, and a wrong first trial is visible on dac_code in the first convert cycle. Flag and justify errors show on done_flag, irq and data_out in the cycle after completion. A result register that is not held shows as a change in data_out during any busy cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TRACK = 2'd1,
    SEQ_CONV  = 2'd2
  } seq_state_e;

  localparam logic [1:0] START_SW   = 2'b00;
  localparam logic [1:0] START_TMRA = 2'b01;
  localparam logic [1:0] START_PIN  = 2'b10;
  localparam logic [1:0] START_TMRB = 2'b11;

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             realign,
  output logic             sar_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign sar_tick = (cnt_q == div_sel);

  always_comb begin
    if (realign)       cnt_d = '0;
    else if (sar_tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: after a realign no tick appears in the next cycle unless the period is one clock
  a_r3_realign_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && (div_sel != '0)) |=> !sar_tick);

endmodule

// File: rtl/sar_trig_sel.sv
module sar_trig_sel
  import sar_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] start_mode,
  input  logic       sw_start,
  input  logic       tmr3_ovf,
  input  logic       tmr2_ovf,
  input  logic       ext_start,
  output logic       start_req,
  output logic       pin_lvl
);

  logic meta_q, sync_q, prev_q;
  logic pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ext_start;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign pin_rise = sync_q & ~prev_q;
  assign pin_lvl  = sync_q;

  always_comb begin
    case (start_mode)
      START_SW:   start_req = sw_start;
      START_TMRA: start_req = tmr3_ovf;
      START_PIN:  start_req = pin_rise;
      START_TMRB: start_req = tmr2_ovf;
      default:    start_req = 1'b0;
    endcase
  end

  // R5: a pin-sourced start needs the synchronized pin to have been low one cycle earlier
  a_r5_pin_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_mode == START_PIN && start_req) |-> (sync_q && !$past(sync_q)));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W         = 10,
  parameter int CONV_CLKS     = 16,
  parameter int LP_TRACK_CLKS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             lp_track,
  input  logic             ext_mode,
  input  logic             pin_lvl,
  input  logic             sar_tick,
  input  logic             cmp_in,
  output logic             accept,
  output logic             done,
  output logic             busy,
  output logic             track,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);

  localparam int               CNT_W      = $clog2(CONV_CLKS);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CLKS - 1);
  localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(LP_TRACK_CLKS - 1);
  localparam logic [RES_W-1:0] MSB_ONLY   = {1'b1, {(RES_W-1){1'b0}}};

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] trial_q, trial_d;
  logic [RES_W-1:0] bitsel_q, bitsel_d;
  logic [RES_W-1:0] result_q, result_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    trial_d  = trial_q;
    bitsel_d = bitsel_q;
    result_d = result_q;
    accept   = 1'b0;
    done     = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_req) begin
          accept = 1'b1;
          cnt_d  = '0;
          if (lp_track && !ext_mode) begin
            state_d = SEQ_TRACK;
          end else begin
            state_d  = SEQ_CONV;
            trial_d  = MSB_ONLY;
            bitsel_d = MSB_ONLY;
          end
        end
      end
      SEQ_TRACK: begin
        if (sar_tick) begin
          if (cnt_q == TRACK_LAST) begin
            state_d  = SEQ_CONV;
            cnt_d    = '0;
            trial_d  = MSB_ONLY;
            bitsel_d = MSB_ONLY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_CONV: begin
        if (sar_tick) begin
          if (bitsel_q != '0) begin
            trial_d  = (cmp_in ? trial_q : (trial_q & ~bitsel_q)) | (bitsel_q >> 1);
            bitsel_d = bitsel_q >> 1;
          end
          if (cnt_q == CONV_LAST) begin
            done     = 1'b1;
            state_d  = SEQ_IDLE;
            result_d = trial_q;
            cnt_d    = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      trial_q  <= '0;
      bitsel_q <= '0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      trial_q  <= trial_d;
      bitsel_q <= bitsel_d;
      result_q <= result_d;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign dac_code = trial_q;
  assign result   = result_q;

  always_comb begin
    if (lp_track)
      track = (state_q == SEQ_TRACK) ||
              ((state_q == SEQ_IDLE) && ext_mode && !pin_lvl);
    else
      track = (state_q == SEQ_IDLE);
  end

  // R10: once running, the sequencer stays busy until its own completion
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R8: at most one trial bit is pending at a time
  a_r8_onehot_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bitsel_q));

  // R11: the stored result moves only on a completion
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result_q));

  // R4: the low-power track phase never exceeds its length
  a_r4_track_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_TRACK) |-> (cnt_q <= TRACK_LAST));

  // R8: the search has used up all trial bits before completion
  a_r8_search_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bitsel_q == '0));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W         = 10,
  parameter int DATA_W        = 16,
  parameter int DIV_W         = 5,
  parameter int CONV_CLKS     = 16,
  parameter int LP_TRACK_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [1:0]        start_mode,
  input  logic              lp_track,
  input  logic              left_just,
  input  logic              irq_en,
  input  logic              sw_start,
  input  logic              sw_clr_flag,
  input  logic              tmr3_ovf,
  input  logic              tmr2_ovf,
  input  logic              ext_start,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic              track,
  output logic              busy,
  output logic              done_flag,
  output logic              irq,
  output logic [DATA_W-1:0] data_out
);

  localparam int PAD_W = DATA_W - RES_W;

  logic             start_req, pin_lvl, sar_tick, accept, done;
  logic             flag_q, flag_d;
  logic [RES_W-1:0] result;

  sar_trig_sel u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_mode (start_mode),
    .sw_start   (sw_start),
    .tmr3_ovf   (tmr3_ovf),
    .tmr2_ovf   (tmr2_ovf),
    .ext_start  (ext_start),
    .start_req  (start_req),
    .pin_lvl    (pin_lvl)
  );

  sar_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_sel  (clk_div),
    .realign  (accept),
    .sar_tick (sar_tick)
  );

  sar_seq_ctrl #(
    .RES_W         (RES_W),
    .CONV_CLKS     (CONV_CLKS),
    .LP_TRACK_CLKS (LP_TRACK_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .lp_track  (lp_track),
    .ext_mode  (start_mode == START_PIN),
    .pin_lvl   (pin_lvl),
    .sar_tick  (sar_tick),
    .cmp_in    (cmp_in),
    .accept    (accept),
    .done      (done),
    .busy      (busy),
    .track     (track),
    .dac_code  (dac_code),
    .result    (result)
  );

  // completion has priority over a software clear
  always_comb begin
    if (done)             flag_d = 1'b1;
    else if (sw_clr_flag) flag_d = 1'b0;
    else                  flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign done_flag = flag_q;
  assign irq       = flag_q & irq_en;
  assign data_out  = left_just ? {result, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, result};

  // R6: busy falling is always accompanied by a set flag
  a_r6_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R7: without a clear the flag stays set
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !sw_clr_flag) |=> done_flag);

  // R7: completion beats a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done_flag);

  // R12: in default tracking mode the sampler tracks exactly when idle
  a_r12_track_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_track |-> (track == !busy));

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

  logic        clk, rst_n;
  logic [4:0]  clk_div;
  logic [1:0]  start_mode;
  logic        lp_track, left_just, irq_en;
  logic        sw_start, sw_clr_flag, tmr3_ovf, tmr2_ovf, ext_start;
  logic        cmp_in;
  logic [9:0]  dac_code;
  logic        track, busy, done_flag, irq;
  logic [15:0] data_out;
  logic [9:0]  vin;
  logic [9:0]  cur_res;

  int n_tests, n_fail;

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start_mode(start_mode),
    .lp_track(lp_track), .left_just(left_just), .irq_en(irq_en),
    .sw_start(sw_start), .sw_clr_flag(sw_clr_flag), .tmr3_ovf(tmr3_ovf),
    .tmr2_ovf(tmr2_ovf), .ext_start(ext_start), .cmp_in(cmp_in),
    .dac_code(dac_code), .track(track), .busy(busy), .done_flag(done_flag),
    .irq(irq), .data_out(data_out)
  );

  // comparator model: keep the trial bit while the trial code does not exceed the input
  assign cmp_in = (dac_code <= vin);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] fmt(input logic [9:0] v, input logic lj);
    return lj ? {v, 6'b0} : {6'b0, v};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [1:0] m, input logic val);
    case (m)
      2'b00: sw_start = val;
      2'b01: tmr3_ovf = val;
      2'b10: ext_start = val;
      default: tmr2_ovf = val;
    endcase
  endtask

  task automatic run_conv(input logic [1:0] m, input logic lp, input int div,
                          input logic [9:0] v, input logic lj, input logic ien,
                          input logic race, input logic retrig);
    int d, exp_len, exp_trk, cnt, trk;
    logic hold_ok;
    logic [9:0] first_dac;
    string lab;
    d       = div + 1;
    exp_len = ((lp && m != 2'b10) ? 19 : 16) * d;
    exp_trk = (lp && m != 2'b10) ? 3 * d : 0;
    lab     = (m == 2'b10) ? "R5 length" : (lp ? "R4 length" : "R3 length");
    start_mode = m; lp_track = lp; clk_div = 5'(div);
    left_just = lj; irq_en = ien; vin = v;
    sw_clr_flag = 1'b1;
    @(negedge clk);
    sw_clr_flag = 1'b0;
    check(done_flag == 1'b0, "R7 clear", int'(done_flag), 0);
    repeat (3) @(negedge clk);
    if (m == 2'b10 && lp) check(track == 1'b1, "R5 track while pin low", int'(track), 1);
    if (!lp) check(track == 1'b1, "R12 idle track", int'(track), 1);
    if (m == 2'b10) begin
      ext_start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R5 sync latency", int'(busy), 0);
      @(negedge clk);
    end else begin
      set_src(m, 1'b1);
      @(negedge clk);
      set_src(m, 1'b0);
    end
    cnt = 0; trk = 0; hold_ok = 1'b1; first_dac = '0;
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      cnt++;
      if (track) trk++;
      if (data_out != fmt(cur_res, lj)) hold_ok = 1'b0;
      if (cnt == exp_trk + 1) first_dac = dac_code;
      if (retrig && cnt == 5) set_src(m, 1'b1);
      if (retrig && cnt == 6) set_src(m, 1'b0);
      if (race && cnt == exp_len) sw_clr_flag = 1'b1;
      @(negedge clk);
    end
    sw_clr_flag = 1'b0;
    if (m != 2'b10) set_src(m, 1'b0);
    check(cnt == exp_len, retrig ? "R10 ignored retrigger" : lab, cnt, exp_len);
    check(trk == exp_trk, "R4 track window", trk, exp_trk);
    check(hold_ok, "R11 result held while busy", int'(hold_ok), 1);
    check(first_dac == 10'h200, "R8 first trial", int'(first_dac), 'h200);
    check(done_flag == 1'b1, race ? "R7 set beats clear" : "R6 flag set", int'(done_flag), 1);
    check(irq == ien, "R6 irq gating", int'(irq), int'(ien));
    check(data_out == fmt(v, lj), "R8 R9 result", int'(data_out), int'(fmt(v, lj)));
    cur_res = v;
    if (m == 2'b10) begin
      if (lp) check(track == 1'b0, "R5 no track while pin high", int'(track), 0);
      ext_start = 1'b0;
      repeat (3) @(negedge clk);
      if (lp) check(track == 1'b1, "R5 track after pin low", int'(track), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic seen;
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; clk_div = '0; start_mode = 2'b00; lp_track = 1'b0;
    left_just = 1'b0; irq_en = 1'b0; sw_start = 1'b0; sw_clr_flag = 1'b0;
    tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; ext_start = 1'b0; vin = '0; cur_res = '0;
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done_flag == 1'b0, "R1 flag", int'(done_flag), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(data_out == 16'h0, "R1 data", int'(data_out), 0);
    check(track == 1'b1, "R1 track", int'(track), 1);

    // R2: sources not selected by mode 01 start nothing
    start_mode = 2'b01;
    sw_start = 1'b1; tmr2_ovf = 1'b1; ext_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; tmr2_ovf = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R2 unselected sources", int'(seen), 0);
    ext_start = 1'b0;
    repeat (4) @(negedge clk);

    run_conv(2'b00, 1'b0, 0, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0);
    run_conv(2'b01, 1'b0, 3, 10'h000, 1'b1, 1'b1, 1'b0, 1'b0);
    run_conv(2'b11, 1'b1, 2, 10'h3FF, 1'b0, 1'b1, 1'b0, 1'b0);
    run_conv(2'b00, 1'b1, 1, 10'h155, 1'b1, 1'b0, 1'b0, 1'b1);
    run_conv(2'b01, 1'b0, 2, 10'h0F3, 1'b0, 1'b0, 1'b0, 1'b1);
    run_conv(2'b10, 1'b0, 2, 10'h3FE, 1'b0, 1'b1, 1'b0, 1'b0);
    run_conv(2'b10, 1'b1, 4, 10'h001, 1'b1, 1'b1, 1'b0, 1'b0);
    run_conv(2'b01, 1'b0, 1, 10'h200, 1'b0, 1'b1, 1'b1, 1'b0);

    // R9: justify acts on the stored code at once
    left_just = 1'b1;
    #1;
    check(data_out == fmt(cur_res, 1'b1), "R9 left live", int'(data_out), int'(fmt(cur_res, 1'b1)));
    left_just = 1'b0;
    #1;
    check(data_out == fmt(cur_res, 1'b0), "R9 right live", int'(data_out), int'(fmt(cur_res, 1'b0)));
    // R6: irq follows the enable while the flag is set
    irq_en = 1'b0;
    #1;
    check(irq == 1'b0, "R6 irq masked", int'(irq), 0);
    // R7: flag stays set with no clear
    repeat (5) @(negedge clk);
    check(done_flag == 1'b1, "R7 sticky", int'(done_flag), 1);

    for (int k = 0; k < 30; k++) begin
      logic [1:0] rm;
      rm = 2'($urandom_range(3, 0));
      run_conv(rm, 1'($urandom_range(1, 0)), int'($urandom_range(7, 0)),
               10'($urandom_range(1023, 0)), 1'($urandom_range(1, 0)),
               1'($urandom_range(1, 0)), 1'b0,
               (rm != 2'b10) ? 1'($urandom_range(1, 0)) : 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule